// File: doc/BRIEF.md
# Register-Amount Shifter with Carry Flag

This block is a purely combinational shifter for a processor datapath. It takes a data operand, a register that holds the shift distance, a two-bit shift-kind select and the incoming carry flag. It returns the shifted value and the carry flag that the operation produces.

The carry follows the architectural rules for register-specified shifts:
- A distance of zero passes both the operand and the carry through unchanged.
- A distance equal to the data width and a distance beyond it produce different carries.
- Rotation uses the distance modulo the width. A nonzero distance that is a multiple of the width leaves the value unchanged but still updates the carry.

Only the low byte of the distance register takes part. The block sits between the register-read stage and the ALU flag logic. It has no state, and its outputs settle within the same cycle.

Top module: `reg_shift_carry`

## Requirements
- R1: Only bits [7:0] of the distance register affect the outputs. Bits above 7 are ignored.
- R2: A distance of 0 gives result = operand and carry = carry-in, for every shift kind.
- R3: With kind 2'b00 (logical left) and distance n in 1..31, the result is operand << n and the carry is operand bit (32 - n).
- R4: Logical left with distance exactly 32 gives result 0 and carry = operand bit 0. With distance 33..255 it gives result 0 and carry 0.
- R5: With kind 2'b01 (logical right) and distance n in 1..31, the result is operand >> n, zero-filled, and the carry is operand bit (n - 1).
- R6: Logical right with distance exactly 32 gives result 0 and carry = operand bit 31. With distance 33..255 it gives result 0 and carry 0.
- R7: With kind 2'b10 (arithmetic right) and distance n in 1..31, the result is operand >> n, filled with operand bit 31, and the carry is operand bit (n - 1).
- R8: Arithmetic right with distance 32..255 gives every result bit equal to operand bit 31, and carry = operand bit 31.
- R9: With kind 2'b11 (rotate right) and remainder r = distance mod 32 nonzero, the result is the operand rotated right by r and the carry is operand bit (r - 1).
- R10: Rotate right with a nonzero distance that is a multiple of 32 (32, 64, ... 224) gives result = operand and carry = operand bit 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| operand_i | input | 32 | Data to be shifted |
| dist_reg_i | input | 32 | Register holding the shift distance; only the low byte is used |
| kind_i | input | 2 | Shift kind: 00 logical left, 01 logical right, 10 arithmetic right, 11 rotate right |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | New carry flag |

## Verification
The bench builds the block with its default parameters: a 32-bit operand and an 8-bit distance field inside a 32-bit register. This makes every distance class reachable: zero, 1 to 31, exactly the width, and 33 to 255, including every rotate multiple of 32. Random stimulus is biased towards those classes and sets random upper register bits. Directed vectors pin the exact boundaries against a reference model that uses widened arithmetic.

// File: rtl/shc_pkg.sv
package shc_pkg;
  typedef enum logic [1:0] {
    SK_LSL = 2'b00,
    SK_LSR = 2'b01,
    SK_ASR = 2'b10,
    SK_ROR = 2'b11
  } shift_kind_e;
endpackage

// File: rtl/shc_amt_class.sv
module shc_amt_class #(
  parameter int WIDTH    = 32,
  parameter int AMT_BITS = 8,
  localparam int LOG2    = $clog2(WIDTH)
) (
  input  logic [AMT_BITS-1:0] amt_i,
  output logic                is_zero_o,
  output logic                is_full_o,
  output logic                is_over_o,
  output logic [LOG2-1:0]     low_o
);
  localparam logic [AMT_BITS-1:0] FULL = AMT_BITS'(WIDTH);

  always_comb begin
    is_zero_o = (amt_i == '0);
    is_full_o = (amt_i == FULL);
    is_over_o = (amt_i > FULL);
    low_o     = amt_i[LOG2-1:0];
  end
endmodule

// File: rtl/shc_barrel.sv
module shc_barrel
  import shc_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG2 = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  logic [LOG2-1:0]  dist_i,
  input  shift_kind_e      kind_i,
  output logic [WIDTH-1:0] data_o
);
  logic             rev;
  logic             rot;
  logic             fill;
  logic [WIDTH-1:0] src;
  logic [WIDTH-1:0] stg [0:LOG2];

  assign rev  = (kind_i == SK_LSL);
  assign rot  = (kind_i == SK_ROR);
  assign fill = (kind_i == SK_ASR) ? data_i[WIDTH-1] : 1'b0;

  // Left shifts reuse the right-shifting stages on a bit-reversed word.
  for (genvar b = 0; b < WIDTH; b++) begin : g_rev_in
    assign src[b] = rev ? data_i[WIDTH-1-b] : data_i[b];
  end

  assign stg[0] = src;

  for (genvar s = 0; s < LOG2; s++) begin : g_stage
    localparam int D = 1 << s;
    logic [WIDTH-1:0] moved;
    assign moved = rot ? {stg[s][D-1:0], stg[s][WIDTH-1:D]}
                       : {{D{fill}}, stg[s][WIDTH-1:D]};
    assign stg[s+1] = dist_i[s] ? moved : stg[s];
  end

  for (genvar b = 0; b < WIDTH; b++) begin : g_rev_out
    assign data_o[b] = rev ? stg[LOG2][WIDTH-1-b] : stg[LOG2][b];
  end
endmodule

// File: rtl/shc_carry_sel.sv
module shc_carry_sel
  import shc_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG2 = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_i,
  input  shift_kind_e      kind_i,
  input  logic             is_zero_i,
  input  logic             is_full_i,
  input  logic             is_over_i,
  input  logic [LOG2-1:0]  low_i,
  input  logic             carry_i,
  output logic             carry_o
);
  logic [LOG2:0]   left_diff;
  logic [LOG2-1:0] left_idx;
  logic [LOG2-1:0] right_idx;

  // Last bit out: position WIDTH-n for left moves, n-1 for right moves.
  assign left_diff = (LOG2+1)'(WIDTH) - {1'b0, low_i};
  assign left_idx  = left_diff[LOG2-1:0];
  assign right_idx = low_i - 1'b1;

  always_comb begin
    carry_o = carry_i;
    if (!is_zero_i) begin
      unique case (kind_i)
        SK_LSL: carry_o = is_over_i ? 1'b0 :
                          is_full_i ? data_i[0] : data_i[left_idx];
        SK_LSR: carry_o = is_over_i ? 1'b0 :
                          is_full_i ? data_i[WIDTH-1] : data_i[right_idx];
        SK_ASR: carry_o = (is_full_i || is_over_i) ? data_i[WIDTH-1]
                                                   : data_i[right_idx];
        SK_ROR: carry_o = (low_i == '0) ? data_i[WIDTH-1] : data_i[right_idx];
        default: carry_o = carry_i;
      endcase
    end
  end
endmodule

// File: rtl/reg_shift_carry.sv
module reg_shift_carry
  import shc_pkg::*;
#(
  parameter int WIDTH    = 32,
  parameter int REG_W    = 32,
  parameter int AMT_BITS = 8,
  localparam int LOG2    = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] operand_i,
  input  logic [REG_W-1:0] dist_reg_i,
  input  logic [1:0]       kind_i,
  input  logic             carry_i,
  output logic [WIDTH-1:0] result_o,
  output logic             carry_o
);
  shift_kind_e         kind;
  logic [AMT_BITS-1:0] amt;
  logic                unused_dist_hi;
  logic                is_zero;
  logic                is_full;
  logic                is_over;
  logic [LOG2-1:0]     low;
  logic [WIDTH-1:0]    barrel_out;

  assign kind           = shift_kind_e'(kind_i);
  assign amt            = dist_reg_i[AMT_BITS-1:0];
  assign unused_dist_hi = ^dist_reg_i[REG_W-1:AMT_BITS];

  shc_amt_class #(.WIDTH(WIDTH), .AMT_BITS(AMT_BITS)) u_class (
    .amt_i     (amt),
    .is_zero_o (is_zero),
    .is_full_o (is_full),
    .is_over_o (is_over),
    .low_o     (low)
  );

  shc_barrel #(.WIDTH(WIDTH)) u_barrel (
    .data_i (operand_i),
    .dist_i (low),
    .kind_i (kind),
    .data_o (barrel_out)
  );

  shc_carry_sel #(.WIDTH(WIDTH)) u_carry (
    .data_i    (operand_i),
    .kind_i    (kind),
    .is_zero_i (is_zero),
    .is_full_i (is_full),
    .is_over_i (is_over),
    .low_i     (low),
    .carry_i   (carry_i),
    .carry_o   (carry_o)
  );

  always_comb begin
    result_o = barrel_out;
    if (is_zero) begin
      result_o = operand_i;
    end else if (is_full || is_over) begin
      unique case (kind)
        SK_LSL, SK_LSR: result_o = '0;
        SK_ASR:         result_o = {WIDTH{operand_i[WIDTH-1]}};
        default:        result_o = barrel_out;
      endcase
    end
  end
endmodule

// File: rtl/reg_shift_carry_chk.sv
module reg_shift_carry_chk #(
  parameter int WIDTH    = 32,
  parameter int REG_W    = 32,
  parameter int AMT_BITS = 8,
  localparam int LOG2    = $clog2(WIDTH)
) (
  input logic [WIDTH-1:0] operand_i,
  input logic [REG_W-1:0] dist_reg_i,
  input logic [1:0]       kind_i,
  input logic             carry_i,
  input logic [WIDTH-1:0] result_o,
  input logic             carry_o
);
  logic [AMT_BITS-1:0] a;
  logic                known;
  assign a = dist_reg_i[AMT_BITS-1:0];
  assign known = !$isunknown({operand_i, a, kind_i, carry_i});

  always_comb begin
    if (known) begin
      if (a == '0) begin
        assert_zero_passthru_R2: assert (result_o == operand_i && carry_o == carry_i)
          else $error("zero distance altered outputs");
      end
      if (kind_i == 2'b00 && a >= AMT_BITS'(WIDTH)) begin
        assert_lsl_clear_R4: assert (result_o == '0)
          else $error("left shift past width not cleared");
      end
      if (kind_i == 2'b01 && a > AMT_BITS'(WIDTH)) begin
        assert_lsr_over_R6: assert (result_o == '0 && carry_o == 1'b0)
          else $error("right shift beyond width wrong");
      end
      if (kind_i == 2'b10 && a >= AMT_BITS'(WIDTH)) begin
        assert_asr_sign_R8: assert (result_o == {WIDTH{operand_i[WIDTH-1]}}
                                    && carry_o == operand_i[WIDTH-1])
          else $error("arithmetic shift past width wrong");
      end
      if (kind_i == 2'b11 && a != '0 && a[LOG2-1:0] == '0) begin
        assert_ror_multiple_R10: assert (result_o == operand_i
                                         && carry_o == operand_i[WIDTH-1])
          else $error("rotate by width multiple wrong");
      end
    end
  end
endmodule

bind reg_shift_carry reg_shift_carry_chk #(
  .WIDTH(WIDTH), .REG_W(REG_W), .AMT_BITS(AMT_BITS)
) u_chk (
  .operand_i  (operand_i),
  .dist_reg_i (dist_reg_i),
  .kind_i     (kind_i),
  .carry_i    (carry_i),
  .result_o   (result_o),
  .carry_o    (carry_o)
);

// File: tb/reg_shift_carry_tb.sv
module reg_shift_carry_tb;
  logic        clk;
  logic [31:0] operand;
  logic [31:0] dist_reg;
  logic [1:0]  kind;
  logic        cin;
  logic [31:0] result;
  logic        cout;
  int          n_checks;
  int          n_fail;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  reg_shift_carry u_dut (
    .operand_i  (operand),
    .dist_reg_i (dist_reg),
    .kind_i     (kind),
    .carry_i    (cin),
    .result_o   (result),
    .carry_o    (cout)
  );

  function automatic logic [32:0] ref_model(input logic [31:0] op, input logic [31:0] dreg,
                                            input logic [1:0] k, input logic c);
    int s;
    int r;
    logic [64:0] w;
    logic [31:0] res;
    logic        cy;
    s = int'(dreg[7:0]);
    res = op;
    cy  = c;
    if (s != 0) begin
      case (k)
        2'b00: begin
          w = {33'b0, op} << ((s > 33) ? 33 : s);
          res = w[31:0];
          cy  = (s > 32) ? 1'b0 : w[32];
        end
        2'b01: begin
          w = {32'b0, op, 1'b0} >> ((s > 33) ? 33 : s);
          res = w[32:1];
          cy  = (s > 32) ? 1'b0 : w[0];
        end
        2'b10: begin
          w = $signed({{32{op[31]}}, op, 1'b0}) >>> ((s > 33) ? 33 : s);
          res = w[32:1];
          cy  = w[0];
        end
        default: begin
          r = s % 32;
          if (r == 0) begin
            res = op;
          end else begin
            res = (op >> r) | (op << (32 - r));
          end
          cy = res[31];
        end
      endcase
    end
    return {cy, res};
  endfunction

  function automatic string req_of(input logic [31:0] dreg, input logic [1:0] k);
    int s;
    s = int'(dreg[7:0]);
    if (s == 0) return "R2";
    case (k)
      2'b00: return (s < 32) ? "R3" : "R4";
      2'b01: return (s < 32) ? "R5" : "R6";
      2'b10: return (s < 32) ? "R7" : "R8";
      default: return (s % 32 != 0) ? "R9" : "R10";
    endcase
  endfunction

  task automatic apply(input logic [31:0] op, input logic [31:0] dreg,
                       input logic [1:0] k, input logic c, input string tag);
    logic [32:0] exp;
    string       req;
    @(posedge clk);
    #1;
    operand  = op;
    dist_reg = dreg;
    kind     = k;
    cin      = c;
    @(negedge clk);
    exp = ref_model(op, dreg, k, c);
    req = (tag.len() != 0) ? tag : req_of(dreg, k);
    n_checks++;
    if ({cout, result} !== exp) begin
      n_fail++;
      $display("FAIL %s kind=%b dist=%h op=%h cin=%b: got res=%h c=%b expected res=%h c=%b",
               req, k, dreg, op, c, result, cout, exp[31:0], exp[32]);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    int unsigned seed;
    logic [31:0] op;
    logic [31:0] d;
    n_checks = 0;
    n_fail   = 0;
    seed = 32'd20250611;
    void'($urandom(seed));

    // R2: distance zero, every kind, both carries
    for (int k = 0; k < 4; k++) begin
      apply(32'hA5A5_0F0F, 32'h0, 2'(k), 1'b1, "R2");
      apply(32'h8000_0001, 32'h0, 2'(k), 1'b0, "R2");
    end
    // R3 / R4 boundaries
    apply(32'h8000_0001, 32'd1,  2'b00, 1'b0, "R3");
    apply(32'h0000_0003, 32'd31, 2'b00, 1'b0, "R3");
    apply(32'h0000_0001, 32'd32, 2'b00, 1'b0, "R4");
    apply(32'hFFFF_FFFF, 32'd33, 2'b00, 1'b1, "R4");
    apply(32'hFFFF_FFFF, 32'd255, 2'b00, 1'b1, "R4");
    // R5 / R6
    apply(32'h0000_0001, 32'd1,  2'b01, 1'b0, "R5");
    apply(32'hC000_0000, 32'd31, 2'b01, 1'b0, "R5");
    apply(32'h8000_0000, 32'd32, 2'b01, 1'b0, "R6");
    apply(32'hFFFF_FFFF, 32'd40, 2'b01, 1'b1, "R6");
    // R7 / R8
    apply(32'h8000_0002, 32'd2,  2'b10, 1'b0, "R7");
    apply(32'h4000_0000, 32'd31, 2'b10, 1'b1, "R7");
    apply(32'h8000_0000, 32'd32, 2'b10, 1'b0, "R8");
    apply(32'h7FFF_FFFF, 32'd200, 2'b10, 1'b1, "R8");
    // R9 / R10
    apply(32'h0000_0001, 32'd1,  2'b11, 1'b0, "R9");
    apply(32'h1234_5678, 32'd36, 2'b11, 1'b0, "R9");
    apply(32'h8000_0000, 32'd32, 2'b11, 1'b0, "R10");
    apply(32'h0000_0001, 32'd224, 2'b11, 1'b1, "R10");
    apply(32'h8765_4321, 32'd64, 2'b11, 1'b0, "R10");
    // R1: upper register bits must not matter
    apply(32'hDEAD_BEEF, 32'hFFFF_FF00, 2'b00, 1'b1, "R1");
    apply(32'hDEAD_BEEF, 32'h0000_0104, 2'b01, 1'b0, "R1");
    apply(32'hDEAD_BEEF, 32'h8000_0020, 2'b10, 1'b0, "R1");
    apply(32'hDEAD_BEEF, 32'h1234_5605, 2'b11, 1'b1, "R1");

    // Constrained random mix
    for (int i = 0; i < 3000; i++) begin
      op = $urandom();
      case ($urandom_range(0, 5))
        0: d = 32'd0;
        1: d = 32'($urandom_range(1, 31));
        2: d = 32'd32;
        3: d = 32'($urandom_range(33, 255));
        4: d = 32'($urandom_range(1, 7) * 32);
        default: d = $urandom();
      endcase
      d[31:8] = 24'($urandom());
      apply(op, d, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), "");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule